// File: doc/BRIEF.md
# Dual-Bank Registered Command Buffer with Parity Check

This block sits between a memory controller and two banks of memory devices. On every rising clock edge it captures a 22-bit command/address word and presents two identical registered copies of it, one for each output bank (A and B). A pair of active-low chip-select inputs, together with a gating-enable input, decides whether the word is accepted. When it is not accepted, the data outputs keep their last value, so the loads see no toggling. The chip selects, two clock-enable bits and two termination-control bits bypass the gating: they are registered and duplicated on every cycle.

The controller sends one parity bit with each word. The block checks it under odd parity over all 22 data bits. A mismatch on an accepted word drives an active-low error flag. The flag asserts one clock after the faulty word reaches the outputs and is held for a fixed number of cycles, which defaults to two. A synchronous active-high reset clears every output and releases the flag.

Top module: `dual_bank_regbuf`

## Requirements
- R1: On a clock edge where `rst` is 1, all data, chip-select, clock-enable and termination outputs of both banks become 0 and `perr_n_o` becomes 1.
- R2: When a word is accepted at an edge, `data_a_o` and `data_b_o` both equal the `data_i` value sampled at that edge.
- R3: A word is accepted when `gate_en_i` is 0 or when at least one bit of `cs_n_i` is 0. When `gate_en_i` is 1 and `cs_n_i` is all ones, both data outputs hold their previous value.
- R4: `cs_n_a_o` and `cs_n_b_o` take the value of `cs_n_i` on every non-reset edge, whatever the gating.
- R5: `cke_a_o`/`cke_b_o` and `odt_a_o`/`odt_b_o` take the values of `cke_i` and `odt_i` on every non-reset edge, whatever the gating.
- R6: Parity is odd. An accepted word is in error when the XOR of all 22 bits of `data_i` and `par_i` equals 0. A word that is not accepted never raises an error.
- R7: For an error word captured at edge k, `perr_n_o` goes to 0 after edge k+1.
- R8: With no further errors, `perr_n_o` stays 0 for exactly HOLD_CYC (2) cycles and then returns to 1.
- R9: An error detected while the flag is held restarts the hold from that error's own assertion edge.
- R10: A reset edge releases a held error flag to 1 at once, and no pending error reappears after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| gate_en_i | input | 1 | 1 enables chip-select gating of the data word |
| cs_n_i | input | 2 | Active-low chip selects |
| data_i | input | 22 | Command/address word |
| par_i | input | 1 | Controller parity bit (odd parity) |
| cke_i | input | 2 | Clock-enable bits, ungated |
| odt_i | input | 2 | Termination-control bits, ungated |
| data_a_o | output | 22 | Registered word, bank A |
| data_b_o | output | 22 | Registered word, bank B |
| cs_n_a_o | output | 2 | Registered chip selects, bank A |
| cs_n_b_o | output | 2 | Registered chip selects, bank B |
| cke_a_o | output | 2 | Registered clock enables, bank A |
| cke_b_o | output | 2 | Registered clock enables, bank B |
| odt_a_o | output | 2 | Registered termination control, bank A |
| odt_b_o | output | 2 | Registered termination control, bank B |
| perr_n_o | output | 1 | Parity error flag, active low |

## Verification
The hardest situation to reach is a second parity error that lands while the hold from a first error is still running, and in particular one that lands on the last held cycle, where a wrong counter would release the flag for a single cycle. Random parity alone seldom produces these spacings. Directed sequences therefore place bad words at gaps of one and two cycles, place a bad word on a gated-off cycle inside the hold, and pulse reset in the middle of a hold. Random traffic with a high bad-parity rate and mixed chip-select patterns then covers the remaining interleavings.

// File: rtl/regbuf_pkg.sv
package regbuf_pkg;
  localparam int DATA_W   = 22;
  localparam int CS_W     = 2;
  localparam int RANK_W   = 2;
  localparam int HOLD_CYC = 2;
  localparam int BANKS    = 2;

  // Odd parity: the word plus its parity bit must XOR to 1.
  function automatic logic odd_par_bad(input logic [DATA_W-1:0] d, input logic p);
    return ~(^{d, p});
  endfunction
endpackage

// File: rtl/regbuf_bank_reg.sv
module regbuf_bank_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ld,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (ld) q <= d;
  end
endmodule

// File: rtl/regbuf_par_chk.sv
module regbuf_par_chk #(
  parameter int DW  = 22,
  parameter int CSW = 2
) (
  input  logic [DW-1:0]  data,
  input  logic           par,
  input  logic           gate_en,
  input  logic [CSW-1:0] cs_n,
  output logic           accept,
  output logic           err_now
);
  always_comb begin
    accept  = !gate_en || !(&cs_n);
    err_now = accept && regbuf_pkg::odd_par_bad(data, par);
  end
endmodule

// File: rtl/regbuf_err_hold.sv
module regbuf_err_hold #(
  parameter int HOLD = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic err_now,
  output logic perr_n
);
  localparam int CW = $clog2(HOLD + 1);
  localparam logic [CW-1:0] HOLD_V = CW'(HOLD);

  logic          err_q;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;

  always_comb begin
    if (err_q)              cnt_d = HOLD_V;
    else if (cnt_q != '0)   cnt_d = cnt_q - 1'b1;
    else                    cnt_d = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      err_q  <= 1'b0;
      cnt_q  <= '0;
      perr_n <= 1'b1;
    end else begin
      err_q  <= err_now;
      cnt_q  <= cnt_d;
      perr_n <= (cnt_d == '0);
    end
  end
endmodule

// File: rtl/dual_bank_regbuf.sv
module dual_bank_regbuf
  import regbuf_pkg::*;
#(
  parameter int DW   = DATA_W,
  parameter int CSW  = CS_W,
  parameter int RW   = RANK_W,
  parameter int HOLD = HOLD_CYC
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           gate_en_i,
  input  logic [CSW-1:0] cs_n_i,
  input  logic [DW-1:0]  data_i,
  input  logic           par_i,
  input  logic [RW-1:0]  cke_i,
  input  logic [RW-1:0]  odt_i,
  output logic [DW-1:0]  data_a_o,
  output logic [DW-1:0]  data_b_o,
  output logic [CSW-1:0] cs_n_a_o,
  output logic [CSW-1:0] cs_n_b_o,
  output logic [RW-1:0]  cke_a_o,
  output logic [RW-1:0]  cke_b_o,
  output logic [RW-1:0]  odt_a_o,
  output logic [RW-1:0]  odt_b_o,
  output logic           perr_n_o
);
  localparam int CTL_W = CSW + 2 * RW;

  logic accept;
  logic err_now;
  logic [DW-1:0]    data_q [BANKS];
  logic [CTL_W-1:0] ctl_q  [BANKS];
  logic [CTL_W-1:0] ctl_d;

  assign ctl_d = {cs_n_i, cke_i, odt_i};

  regbuf_par_chk #(.DW(DW), .CSW(CSW)) par_i0 (
    .data(data_i), .par(par_i), .gate_en(gate_en_i), .cs_n(cs_n_i),
    .accept(accept), .err_now(err_now)
  );

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    regbuf_bank_reg #(.W(DW)) data_reg (
      .clk(clk), .rst(rst), .ld(accept), .d(data_i), .q(data_q[b])
    );
    regbuf_bank_reg #(.W(CTL_W)) ctl_reg (
      .clk(clk), .rst(rst), .ld(1'b1), .d(ctl_d), .q(ctl_q[b])
    );
  end

  regbuf_err_hold #(.HOLD(HOLD)) hold_i (
    .clk(clk), .rst(rst), .err_now(err_now), .perr_n(perr_n_o)
  );

  assign data_a_o = data_q[0];
  assign data_b_o = data_q[1];
  assign {cs_n_a_o, cke_a_o, odt_a_o} = ctl_q[0];
  assign {cs_n_b_o, cke_b_o, odt_b_o} = ctl_q[1];
endmodule

// File: rtl/dual_bank_regbuf_chk.sv
module dual_bank_regbuf_chk #(
  parameter int DW  = 22,
  parameter int CSW = 2,
  parameter int RW  = 2
) (
  input logic           clk,
  input logic           rst,
  input logic           gate_en_i,
  input logic [CSW-1:0] cs_n_i,
  input logic [DW-1:0]  data_i,
  input logic           par_i,
  input logic [RW-1:0]  cke_i,
  input logic [DW-1:0]  data_a_o,
  input logic [DW-1:0]  data_b_o,
  input logic [CSW-1:0] cs_n_a_o,
  input logic [RW-1:0]  cke_a_o,
  input logic           perr_n_o
);
  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (data_a_o == '0 && data_b_o == '0 && perr_n_o));

  assert_banks_match_R2: assert property (@(posedge clk) disable iff (rst)
    data_a_o == data_b_o);

  assert_gated_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (gate_en_i && (&cs_n_i)) |=> $stable(data_a_o));

  assert_cs_follow_R4: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> cs_n_a_o == $past(cs_n_i));

  assert_cke_follow_R5: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> cke_a_o == $past(cke_i));

  assert_err_raise_R7: assert property (@(posedge clk) disable iff (rst)
    ((!gate_en_i || !(&cs_n_i)) && !(^{data_i, par_i})) |-> ##2 !perr_n_o);

  assert_hold_len_R8: assert property (@(posedge clk) disable iff (rst)
    $fell(perr_n_o) |=> !perr_n_o);
endmodule

bind dual_bank_regbuf dual_bank_regbuf_chk #(.DW(DW), .CSW(CSW), .RW(RW)) chk_i (
  .clk(clk), .rst(rst), .gate_en_i(gate_en_i), .cs_n_i(cs_n_i), .data_i(data_i),
  .par_i(par_i), .cke_i(cke_i), .data_a_o(data_a_o), .data_b_o(data_b_o),
  .cs_n_a_o(cs_n_a_o), .cke_a_o(cke_a_o), .perr_n_o(perr_n_o)
);

// File: tb/dual_bank_regbuf_tb_top.sv
module dual_bank_regbuf_tb_top;
  localparam int DW = 22;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic gate_en_i = 1'b0;
  logic [1:0] cs_n_i = 2'b11;
  logic [DW-1:0] data_i = '0;
  logic par_i = 1'b1;
  logic [1:0] cke_i = '0, odt_i = '0;
  logic [DW-1:0] data_a_o, data_b_o;
  logic [1:0] cs_n_a_o, cs_n_b_o, cke_a_o, cke_b_o, odt_a_o, odt_b_o;
  logic perr_n_o;

  int checks = 0, fails = 0;
  bit done = 0;

  // expected state
  logic [DW-1:0] e_data = '0;
  logic [1:0] e_cs = '0, e_cke = '0, e_odt = '0;
  logic e_stage = 0, e_perr_n = 1;
  int e_cnt = 0;

  always #2.5 clk = ~clk;

  dual_bank_regbuf dut_i (
    .clk(clk), .rst(rst), .gate_en_i(gate_en_i), .cs_n_i(cs_n_i), .data_i(data_i),
    .par_i(par_i), .cke_i(cke_i), .odt_i(odt_i), .data_a_o(data_a_o), .data_b_o(data_b_o),
    .cs_n_a_o(cs_n_a_o), .cs_n_b_o(cs_n_b_o), .cke_a_o(cke_a_o), .cke_b_o(cke_b_o),
    .odt_a_o(odt_a_o), .odt_b_o(odt_b_o), .perr_n_o(perr_n_o)
  );

  function automatic logic good_par(input logic [DW-1:0] d);
    return ~(^d);
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_edge();
    logic acc;
    int ncnt;
    if (rst) begin
      e_data = '0; e_cs = '0; e_cke = '0; e_odt = '0;
      e_stage = 0; e_cnt = 0; e_perr_n = 1;
    end else begin
      acc = !gate_en_i || (cs_n_i != 2'b11);
      ncnt = e_stage ? 2 : (e_cnt > 0 ? e_cnt - 1 : 0);
      e_cnt = ncnt;
      e_perr_n = (ncnt == 0);
      e_stage = acc && !(^{data_i, par_i});
      if (acc) e_data = data_i;
      e_cs = cs_n_i; e_cke = cke_i; e_odt = odt_i;
    end
  endtask

  task automatic check_all();
    chk("R1 R2 R3 data bank A", 64'(data_a_o), 64'(e_data));
    chk("R2 data bank B", 64'(data_b_o), 64'(e_data));
    chk("R4 chip selects", 64'({cs_n_a_o, cs_n_b_o}), 64'({e_cs, e_cs}));
    chk("R5 cke/odt", 64'({cke_a_o, cke_b_o, odt_a_o, odt_b_o}), 64'({e_cke, e_cke, e_odt, e_odt}));
    chk("R6 R7 R8 R9 R10 error flag", 64'(perr_n_o), 64'(e_perr_n));
  endtask

  // drive one cycle: inputs set at negedge, model at posedge, check at next negedge
  task automatic cyc(input logic r, input logic g, input logic [1:0] cs,
                     input logic [DW-1:0] d, input logic bad);
    rst = r; gate_en_i = g; cs_n_i = cs; data_i = d;
    par_i = bad ? ~good_par(d) : good_par(d);
    cke_i = 2'($urandom); odt_i = 2'($urandom);
    @(posedge clk); #1; model_edge();
    @(negedge clk); check_all();
  endtask

  initial begin
    void'($urandom(32'h5EED_0042));
    @(negedge clk);
    // R1: reset state
    repeat (3) cyc(1, 0, 2'b11, 22'h3FFFFF, 1);
    // R2 R6 R7 R8: ungated single error, then clean cycles
    cyc(0, 0, 2'b11, 22'h155555, 1);
    repeat (4) cyc(0, 0, 2'b11, 22'h0ABCDE, 0);
    // R3 R6: gated off, bad parity ignored, data holds
    repeat (3) cyc(0, 1, 2'b11, 22'h2AAAAA, 1);
    // R3: one chip select low accepts
    cyc(0, 1, 2'b10, 22'h012345, 0);
    cyc(0, 1, 2'b01, 22'h054321, 1);
    repeat (4) cyc(0, 1, 2'b11, 22'h3C3C3C, 0);
    // R9: errors spaced by 1 and 2 cycles
    cyc(0, 0, 2'b00, 22'h000001, 1);
    cyc(0, 0, 2'b00, 22'h000002, 0);
    cyc(0, 0, 2'b00, 22'h000003, 1);
    cyc(0, 0, 2'b00, 22'h000004, 1);
    // gated bad word inside hold must not extend it
    cyc(0, 1, 2'b11, 22'h000005, 1);
    repeat (4) cyc(0, 0, 2'b00, 22'h000006, 0);
    // R10: reset during hold
    cyc(0, 0, 2'b00, 22'h111111, 1);
    cyc(0, 0, 2'b00, 22'h222222, 0);
    cyc(1, 0, 2'b00, 22'h333333, 1);
    repeat (3) cyc(0, 0, 2'b00, 22'h044444, 0);
    // random traffic
    for (int i = 0; i < 3000; i++) begin
      cyc(($urandom % 100) == 0, 1'($urandom), 2'($urandom), 22'($urandom),
          ($urandom % 3) == 0);
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule